// File: doc/BRIEF.md
# Configuration-Port Watchdog Countdown Timer

This block is the watchdog function that sits behind an index/data configuration port. Software writes a timeout into an 8-bit count register. A prescaler driven by the system clock makes second ticks, and from these minute ticks. On each tick of the selected unit the count drops by one. The same register is the live count. Writing a nonzero value starts or restarts the countdown. Writing zero stops it. Reading it returns the units left.

When the count reaches zero, the block latches an expiry flag and pulls its active-low watchdog output low. It can also drive a keyboard-reset line low for a fixed number of clock cycles. A status register holds the expiry flag and two enable bits. When an enable bit is set, a keyboard or mouse event reloads a running count from the last timeout written. A parameter selects the index pair for the timeout and control registers.

Top module: `sio_wdog_top`

## Requirements
- R1: After reset the count is 0, `wdt_out_n` and `kbrst_n` are 1, and the timeout, control and status registers all read 0x00.
- R2: Writing a nonzero value N to the timeout register (index 0xF6, or 0xF4 with `ALT_MAP`=1) loads the count with N. A read of that index returns the units left. In seconds mode the count falls by one every `TICK_CYCLES` clock cycles, measured from the write edge.
- R3: Writing 0 to the timeout register stops the watchdog. The count stays 0 and no expiry follows.
- R4: When a running count reaches 0, status bit 4 (index 0xF7) is set and `wdt_out_n` goes low on the same edge. Both hold until the timeout register is written, or until status is written with bit 4 equal to 0.
- R5: With control bit 1 set (index 0xF5, or 0xF3 with `ALT_MAP`=1), `kbrst_n` is low for exactly `PULSE_CYCLES` cycles, starting at the expiry edge. This happens once per expiry. With bit 1 clear, `kbrst_n` stays high.
- R6: With control bit 3 set, one unit is 60 seconds, so each count step takes 60*`TICK_CYCLES` cycles. With bit 3 clear, one unit is one second.
- R7: With status bit 6 set, a `kbd_evt` cycle during a running count reloads the last timeout written and restarts the prescaler. Status bit 7 does the same for `mouse_evt`. When the bit is clear, the event leaves the count unchanged.
- R8: Writing a new nonzero timeout while the count is running restarts the countdown from the new value, on a fresh prescaler phase.
- R9: With `ALT_MAP`=1, the timeout and control registers move to indices 0xF4 and 0xF3. The status register stays at 0xF7, and 0xF6 reads 0.
- R10: Writes to other indices have no effect. Control bits other than 1 and 3 read 0. Status bits other than 7, 6 and 4 read 0. Software cannot set status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe from the configuration front end |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_idx` (combinational) |
| kbd_evt | input | 1 | Keyboard activity event, one cycle |
| mouse_evt | input | 1 | Mouse activity event, one cycle |
| wdt_out_n | output | 1 | Active-low watchdog output |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |

## Verification
The main instance is built with `TICK_CYCLES`=4 and `PULSE_CYCLES`=3. A second therefore lasts four cycles, and a 60-second minute step lasts 240 cycles. This brings minute-mode expiry, the exact pulse length, and many random timeout and wait pairs within a short run. A second instance with `ALT_MAP`=1 checks that the timeout and control registers move while status stays put.

// File: rtl/sio_wdog_pkg.sv
package sio_wdog_pkg;
   localparam int CNT_W        = 8;
   localparam int SEC_PER_MIN  = 60;
   localparam logic [7:0] STS_IDX = 8'hF7;
   localparam int CTL_KBRST_BIT = 1;
   localparam int CTL_MIN_BIT   = 3;
   localparam int STS_EXP_BIT   = 4;
   localparam int STS_KBD_BIT   = 6;
   localparam int STS_MOUSE_BIT = 7;

   typedef struct packed {
      logic wr_tmo;
      logic wr_ctl;
      logic wr_sts;
   } wr_strobe_t;

   function automatic logic [7:0] tmo_index(input int alt);
      return (alt != 0) ? 8'hF4 : 8'hF6;
   endfunction

   function automatic logic [7:0] ctl_index(input int alt);
      return (alt != 0) ? 8'hF3 : 8'hF5;
   endfunction
endpackage

// File: rtl/sio_wdog_regs.sv
module sio_wdog_regs
   import sio_wdog_pkg::*;
#(
   parameter int ALT_MAP = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [7:0]       idx,
   input  logic [7:0]       wdata,
   input  logic [CNT_W-1:0] count,
   input  logic             expired,
   output wr_strobe_t       stb,
   output logic             clr_exp,
   output logic             ctl_kbrst,
   output logic             ctl_min,
   output logic             sts_kbd,
   output logic             sts_mouse,
   output logic [7:0]       rdata
);
   localparam logic [7:0] TMO_IDX = tmo_index(ALT_MAP);
   localparam logic [7:0] CTL_IDX = ctl_index(ALT_MAP);

   if (ALT_MAP != 0 && ALT_MAP != 1) begin : g_bad_map
      $error("ALT_MAP must be 0 or 1");
   end

   always_comb begin
      stb.wr_tmo = we && (idx == TMO_IDX);
      stb.wr_ctl = we && (idx == CTL_IDX);
      stb.wr_sts = we && (idx == STS_IDX);
   end

   assign clr_exp = stb.wr_sts && !wdata[STS_EXP_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_kbrst <= 1'b0;
         ctl_min   <= 1'b0;
         sts_kbd   <= 1'b0;
         sts_mouse <= 1'b0;
      end else begin
         if (stb.wr_ctl) begin
            ctl_kbrst <= wdata[CTL_KBRST_BIT];
            ctl_min   <= wdata[CTL_MIN_BIT];
         end
         if (stb.wr_sts) begin
            sts_kbd   <= wdata[STS_KBD_BIT];
            sts_mouse <= wdata[STS_MOUSE_BIT];
         end
      end
   end

   always_comb begin
      rdata = 8'h00;
      if (idx == TMO_IDX) begin
         rdata = count;
      end else if (idx == CTL_IDX) begin
         rdata[CTL_KBRST_BIT] = ctl_kbrst;
         rdata[CTL_MIN_BIT]   = ctl_min;
      end else if (idx == STS_IDX) begin
         rdata[STS_EXP_BIT]   = expired;
         rdata[STS_KBD_BIT]   = sts_kbd;
         rdata[STS_MOUSE_BIT] = sts_mouse;
      end
   end
endmodule

// File: rtl/sio_wdog_tick.sv
module sio_wdog_tick
   import sio_wdog_pkg::*;
#(
   parameter int TICK_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic min_mode,
   output logic unit_tick
);
   localparam int MW = $clog2(SEC_PER_MIN);
   localparam logic [MW-1:0] M_LAST = MW'(SEC_PER_MIN - 1);

   logic          sec_tick;
   logic [MW-1:0] min_q;

   if (TICK_CYCLES < 1) begin : g_bad_tick
      $error("TICK_CYCLES must be at least 1");
   end

   if (TICK_CYCLES == 1) begin : g_direct
      assign sec_tick = 1'b1;
   end else begin : g_div
      localparam int PW = $clog2(TICK_CYCLES);
      localparam logic [PW-1:0] P_LAST = PW'(TICK_CYCLES - 1);
      logic [PW-1:0] pre_q;
      assign sec_tick = (pre_q == P_LAST);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         pre_q <= '0;
         else if (restart)   pre_q <= '0;
         else if (sec_tick)  pre_q <= '0;
         else                pre_q <= pre_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        min_q <= '0;
      else if (restart)  min_q <= '0;
      else if (sec_tick) min_q <= (min_q == M_LAST) ? '0 : min_q + 1'b1;
   end

   assign unit_tick = min_mode ? (sec_tick && !restart && min_q == M_LAST)
                               : (sec_tick && !restart);
endmodule

// File: rtl/sio_wdog_count.sv
module sio_wdog_count
   import sio_wdog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_tmo,
   input  logic [CNT_W-1:0] tmo_val,
   input  logic             unit_tick,
   input  logic             reload_req,
   input  logic             clr_exp,
   output logic [CNT_W-1:0] count,
   output logic             expired,
   output logic             expire_stb,
   output logic             restart
);
   logic [CNT_W-1:0] reload_q;
   logic             running;
   logic             reload_live;

   assign running     = (count != '0);
   assign reload_live = reload_req && running && !wr_tmo;
   assign restart     = wr_tmo || reload_live;
   assign expire_stb  = !restart && running && unit_tick &&
                        (count == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         reload_q <= '0;
         expired  <= 1'b0;
      end else begin
         if (wr_tmo) begin
            count    <= tmo_val;
            reload_q <= tmo_val;
         end else if (reload_live) begin
            count <= reload_q;
         end else if (running && unit_tick) begin
            count <= count - 1'b1;
         end

         if (expire_stb)            expired <= 1'b1;
         else if (wr_tmo || clr_exp) expired <= 1'b0;
      end
   end
endmodule

// File: rtl/sio_wdog_pulse.sv
module sio_wdog_pulse #(
   parameter int PULSE_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse_n
);
   if (PULSE_CYCLES < 1) begin : g_bad_pulse
      $error("PULSE_CYCLES must be at least 1");
   end

   if (PULSE_CYCLES == 1) begin : g_single
      logic act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) act_q <= 1'b0;
         else        act_q <= fire;
      end
      assign pulse_n = !act_q;
   end else begin : g_count
      localparam int W = $clog2(PULSE_CYCLES + 1);
      localparam logic [W-1:0] LEN = W'(PULSE_CYCLES);
      logic [W-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            left_q <= '0;
         else if (fire)         left_q <= LEN;
         else if (left_q != '0) left_q <= left_q - 1'b1;
      end
      assign pulse_n = (left_q == '0);
   end
endmodule

// File: rtl/sio_wdog_top.sv
module sio_wdog_top
   import sio_wdog_pkg::*;
#(
   parameter int TICK_CYCLES  = 1000,
   parameter int PULSE_CYCLES = 16,
   parameter int ALT_MAP      = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [7:0] cfg_idx,
   input  logic [7:0] cfg_wdata,
   output logic [7:0] cfg_rdata,
   input  logic       kbd_evt,
   input  logic       mouse_evt,
   output logic       wdt_out_n,
   output logic       kbrst_n
);
   wr_strobe_t       stb;
   logic             clr_exp;
   logic             ctl_kbrst, ctl_min, sts_kbd, sts_mouse;
   logic [CNT_W-1:0] count_w;
   logic             expired, expire_stb, restart, unit_tick;
   logic             reload_req;

   assign reload_req = (kbd_evt && sts_kbd) || (mouse_evt && sts_mouse);

   sio_wdog_regs #(.ALT_MAP(ALT_MAP)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
      .count(count_w), .expired(expired), .stb(stb), .clr_exp(clr_exp),
      .ctl_kbrst(ctl_kbrst), .ctl_min(ctl_min), .sts_kbd(sts_kbd),
      .sts_mouse(sts_mouse), .rdata(cfg_rdata)
   );

   sio_wdog_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(restart), .min_mode(ctl_min),
      .unit_tick(unit_tick)
   );

   sio_wdog_count u_count (
      .clk(clk), .rst_n(rst_n), .wr_tmo(stb.wr_tmo), .tmo_val(cfg_wdata),
      .unit_tick(unit_tick), .reload_req(reload_req), .clr_exp(clr_exp),
      .count(count_w), .expired(expired), .expire_stb(expire_stb),
      .restart(restart)
   );

   sio_wdog_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(expire_stb && ctl_kbrst),
      .pulse_n(kbrst_n)
   );

   assign wdt_out_n = !expired;
endmodule

// File: rtl/sio_wdog_chk.sv
module sio_wdog_chk
   import sio_wdog_pkg::*;
#(
   parameter int ALT_MAP = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [7:0]       cfg_idx,
   input logic [7:0]       cfg_wdata,
   input logic             kbd_evt,
   input logic             mouse_evt,
   input logic             wdt_out_n,
   input logic             kbrst_n,
   input logic [CNT_W-1:0] count_w
);
   localparam logic [7:0] TMO_IDX = tmo_index(ALT_MAP);

   logic wr_tmo_c, clr_c;
   assign wr_tmo_c = cfg_we && cfg_idx == TMO_IDX;
   assign clr_c    = cfg_we && cfg_idx == STS_IDX && !cfg_wdata[STS_EXP_BIT];

   // R2: without writes or events the count falls by at most one per cycle
   a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (count_w != '0 && !cfg_we && !kbd_evt && !mouse_evt) |=>
      (count_w == $past(count_w) || count_w == $past(count_w) - 1'b1));

   // R3: a zero timeout write leaves the count at zero and the output high
   a_r3_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tmo_c && cfg_wdata == 8'h00) |=> (count_w == '0 && wdt_out_n));

   // R4: the output only falls when the count is zero
   a_r4_fall_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_out_n) |-> (count_w == '0));

   // R4: an asserted output holds until a timeout write or status clear
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wdt_out_n && !wr_tmo_c && !clr_c) |=> !wdt_out_n);

   // R5: the keyboard-reset pulse starts only on an expiry edge
   a_r5_pulse_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(kbrst_n) |-> $fell(wdt_out_n));
endmodule

bind sio_wdog_top sio_wdog_chk #(.ALT_MAP(ALT_MAP)) u_chk (.*);

// File: tb/sim_sio_wdog_top.sv
module sim_sio_wdog_top;
   localparam int TPS = 4;
   localparam int PL  = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_idx = 8'h00;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       kbd_evt = 1'b0, mouse_evt = 1'b0;
   logic       wdt_out_n, kbrst_n;

   logic       we1 = 1'b0;
   logic [7:0] idx1 = 8'h00, wd1 = 8'h00;
   logic [7:0] rd1;
   logic       out1_n, kb1_n;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   sio_wdog_top #(.TICK_CYCLES(TPS), .PULSE_CYCLES(PL), .ALT_MAP(0)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .kbd_evt(kbd_evt),
      .mouse_evt(mouse_evt), .wdt_out_n(wdt_out_n), .kbrst_n(kbrst_n)
   );

   sio_wdog_top #(.TICK_CYCLES(TPS), .PULSE_CYCLES(PL), .ALT_MAP(1)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_we(we1), .cfg_idx(idx1),
      .cfg_wdata(wd1), .cfg_rdata(rd1), .kbd_evt(1'b0),
      .mouse_evt(1'b0), .wdt_out_n(out1_n), .kbrst_n(kb1_n)
   );

   function automatic int left_after(input int n, input int k, input int unit);
      return n - k / unit;
   endfunction

   task automatic chk(input string tag, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic wr(input logic [7:0] i, input logic [7:0] d);
      cfg_idx = i; cfg_wdata = d; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] i, output int v);
      cfg_idx = i;
      #1;
      v = int'(cfg_rdata);
   endtask

   task automatic cyc(input int k);
      repeat (k) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int v;
      void'($urandom(32'd4242));
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      rd(8'hF6, v); chk("R1 count", v, 0);
      rd(8'hF5, v); chk("R1 ctrl", v, 0);
      rd(8'hF7, v); chk("R1 status", v, 0);
      chk("R1 wdt_out_n", int'(wdt_out_n), 1);
      chk("R1 kbrst_n", int'(kbrst_n), 1);

      // R2 directed countdown
      wr(8'hF6, 8'd5);
      rd(8'hF6, v); chk("R2 load", v, 5);
      cyc(3); rd(8'hF6, v); chk("R2 before step", v, 5);
      cyc(1); rd(8'hF6, v); chk("R2 first step", v, 4);
      cyc(15); chk("R4 not yet", int'(wdt_out_n), 1);
      cyc(1);
      chk("R4 expired out", int'(wdt_out_n), 0);
      rd(8'hF7, v); chk("R4 status bit4", v, 8'h10);
      rd(8'hF6, v); chk("R2 zero left", v, 0);
      chk("R5 no pulse when ctrl bit1 clear", int'(kbrst_n), 1);

      // R4 hold and clear by status write
      cyc(20); chk("R4 hold", int'(wdt_out_n), 0);
      wr(8'hF7, 8'h00);
      chk("R4 cleared by status", int'(wdt_out_n), 1);
      rd(8'hF7, v); chk("R4 status clear", v, 0);
      // R4 clear by timeout write
      wr(8'hF6, 8'd1); cyc(4);
      chk("R4 second expiry", int'(wdt_out_n), 0);
      wr(8'hF6, 8'd9);
      chk("R4 cleared by timeout write", int'(wdt_out_n), 1);

      // R5 keyboard-reset pulse
      wr(8'hF5, 8'h02);
      wr(8'hF6, 8'd2);
      cyc(7); chk("R5 pre kbrst", int'(kbrst_n), 1);
      cyc(1); chk("R5 kbrst low", int'(kbrst_n), 0);
      chk("R5 out low", int'(wdt_out_n), 0);
      cyc(2); chk("R5 kbrst last", int'(kbrst_n), 0);
      cyc(1); chk("R5 kbrst end", int'(kbrst_n), 1);
      cyc(20); chk("R5 once per expiry", int'(kbrst_n), 1);

      // R6 minute mode
      wr(8'hF5, 8'h08);
      wr(8'hF6, 8'd2);
      cyc(239); rd(8'hF6, v); chk("R6 before minute", v, 2);
      cyc(1); rd(8'hF6, v); chk("R6 one minute", v, 1);
      cyc(239); chk("R6 not yet", int'(wdt_out_n), 1);
      cyc(1); chk("R6 expired", int'(wdt_out_n), 0);
      wr(8'hF5, 8'h00);

      // R7 keyboard reload
      wr(8'hF7, 8'h40);
      wr(8'hF6, 8'd3);
      cyc(6); rd(8'hF6, v); chk("R7 counting", v, 2);
      kbd_evt = 1'b1; cyc(1); kbd_evt = 1'b0;
      rd(8'hF6, v); chk("R7 kbd reload", v, 3);
      cyc(11); rd(8'hF6, v); chk("R7 restarted phase", v, 1);
      chk("R7 not expired", int'(wdt_out_n), 1);
      cyc(1); chk("R7 expiry after reload", int'(wdt_out_n), 0);
      // R7 mouse ignored while bit7 clear
      wr(8'hF6, 8'd3);
      cyc(2);
      mouse_evt = 1'b1; cyc(1); mouse_evt = 1'b0;
      rd(8'hF6, v); chk("R7 mouse ignored", v, 3);
      cyc(1); rd(8'hF6, v); chk("R7 mouse ignored phase", v, 2);
      // R7 mouse reload with bit7 set
      wr(8'hF7, 8'h80);
      cyc(1);
      mouse_evt = 1'b1; cyc(1); mouse_evt = 1'b0;
      rd(8'hF6, v); chk("R7 mouse reload", v, 3);

      // R3 stop
      wr(8'hF6, 8'd3); cyc(5);
      wr(8'hF6, 8'd0);
      rd(8'hF6, v); chk("R3 stopped", v, 0);
      cyc(50); chk("R3 no expiry", int'(wdt_out_n), 1);
      rd(8'hF7, v); chk("R3 status", v, 8'h80);

      // R8 restart with new value
      wr(8'hF6, 8'd4); cyc(6);
      wr(8'hF6, 8'd2);
      rd(8'hF6, v); chk("R8 new value", v, 2);
      cyc(7); chk("R8 not yet", int'(wdt_out_n), 1);
      cyc(1); chk("R8 expiry from new value", int'(wdt_out_n), 0);

      // R10 ignored writes and masked bits
      wr(8'hF6, 8'd0);
      wr(8'h10, 8'hFF);
      rd(8'hF6, v); chk("R10 other index count", v, 0);
      rd(8'hF5, v); chk("R10 other index ctrl", v, 0);
      wr(8'hF5, 8'hFF); rd(8'hF5, v); chk("R10 ctrl mask", v, 8'h0A);
      wr(8'hF7, 8'hFF); rd(8'hF7, v); chk("R10 status mask", v, 8'hC0);
      chk("R10 out untouched", int'(wdt_out_n), 1);
      wr(8'hF5, 8'h00); wr(8'hF7, 8'h00);

      // R9 alternate map on u1
      idx1 = 8'hF4; wd1 = 8'd3; we1 = 1'b1; cyc(1); we1 = 1'b0;
      #1; chk("R9 alt timeout", int'(rd1), 3);
      idx1 = 8'hF6; #1; chk("R9 old index empty", int'(rd1), 0);
      idx1 = 8'hF3; wd1 = 8'h08; we1 = 1'b1; cyc(1); we1 = 1'b0;
      #1; chk("R9 alt ctrl", int'(rd1), 8'h08);
      idx1 = 8'hF7; wd1 = 8'h40; we1 = 1'b1; cyc(1); we1 = 1'b0;
      #1; chk("R9 status fixed", int'(rd1), 8'h40);

      // R2 random timeouts and wait points
      for (int it = 0; it < 25; it++) begin
         int n, k;
         n = int'($urandom_range(12, 1));
         k = int'($urandom_range(n * TPS - 1, 0));
         wr(8'hF6, 8'(n));
         cyc(k);
         rd(8'hF6, v); chk("R2 random left", v, left_after(n, k, TPS));
         chk("R2 random running", int'(wdt_out_n), 1);
         cyc(n * TPS - k);
         chk("R4 random expiry", int'(wdt_out_n), 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule